// File: doc/BRIEF.md
# Six-Channel Sample Frame Serializer

This block turns one set of multichannel samples into a fixed 17-byte frame and hands the frame out one byte at a time on a valid/ready byte stream. The stream is meant to feed a UART transmitter. A one-cycle start strobe captures six 16-bit sample words, a 4-bit button nibble and an 8-bit version value. The block then walks through the frame. Samples nominally arrive at 256 Hz, so a frame normally drains long before the next strobe.

Every frame opens with a two-byte sync marker, then the version and a rolling 8-bit frame number that the block keeps internally. Next come the six channels in ascending order, each as low byte then high byte, and finally the button byte. The `busy` output is high from capture until the last byte is taken. A strobe that arrives while `busy` is high is discarded and counted in a saturating overrun counter.

Top module: `sample_framer`

## Requirements
- R1: After reset `busy` and `tx_valid` are low, `overrun_count` is 0, and the first frame carries frame number 0.
- R2: Frame bytes 1 and 2 are 0xA5 and 0x5A, in that order.
- R3: Byte 3 is the captured version. Byte 4 is the frame number, which rises by one after each completed frame and wraps from 255 to 0.
- R4: Bytes 5 to 16 carry channels 0 to 5 in order, each as bits 7:0 then bits 15:8 of its word. Channel k occupies bits 16k+15:16k of `samples`.
- R5: Byte 17 is {4'b0000, buttons}, with button b1 in bit 0.
- R6: A frame is exactly 17 accepted bytes. In the cycle after the 17th handshake, `busy` and `tx_valid` are low.
- R7: The byte position advances only on a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, `tx_data` holds its value.
- R8: Frame contents are captured at start. Changing `version`, `buttons` or `samples` during the frame has no effect on the bytes sent.
- R9: A start seen while `busy` is high is ignored and does not restart or alter the frame. Each such cycle adds one to `overrun_count`, which saturates at its maximum (255).
- R10: `busy` rises in the cycle after an accepted start, and `tx_valid` equals `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture strobe for a new frame |
| version | input | 8 | Version value for byte 3 |
| buttons | input | 4 | Button states, b1 in bit 0 |
| samples | input | 96 | Six 16-bit sample words, channel 0 lowest |
| busy | output | 1 | Frame in progress |
| tx_valid | output | 1 | Byte on tx_data is valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_data | output | 8 | Current frame byte |
| overrun_count | output | 8 | Saturating count of dropped starts |

## Verification
The hardest condition to reach from the ports is a saturated overrun counter. It takes 255 dropped strobes, and all of them must land while a frame is still in flight. The stimulus gets there by holding `tx_ready` low, so one frame stays stuck at its first byte, and then holding `start` high for several hundred cycles before draining. The wrap of the frame number also needs more than 256 completed frames, so the bench pushes them back to back with `tx_ready` held high.

// File: rtl/sample_framer.sv
module sample_framer #(
  parameter int CHANNELS = 6,
  parameter int OVR_W = 8,
  parameter logic [7:0] SYNC_HI = 8'hA5,
  parameter logic [7:0] SYNC_LO = 8'h5A
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [7:0]               version,
  input  logic [3:0]               buttons,
  input  logic [CHANNELS*16-1:0]   samples,
  output logic                     busy,
  output logic                     tx_valid,
  input  logic                     tx_ready,
  output logic [7:0]               tx_data,
  output logic [OVR_W-1:0]         overrun_count
);

  localparam int NBYTES = 5 + 2 * CHANNELS;
  localparam int IDX_W  = $clog2(NBYTES);
  localparam int CH_BASE = 4;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NBYTES - 1);

  logic                   busy_q;
  logic [IDX_W-1:0]       idx;
  logic [7:0]             fno;
  logic [7:0]             ver_q;
  logic [3:0]             btn_q;
  logic [CHANNELS*16-1:0] smp_q;
  logic [7:0]             frame_b [NBYTES];

  wire fire = busy_q & tx_ready;
  wire done = fire & (idx == LAST);

  assign busy     = busy_q;
  assign tx_valid = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx    <= '0;
      fno    <= '0;
      ver_q  <= '0;
      btn_q  <= '0;
      smp_q  <= '0;
    end else if (!busy_q && start) begin
      busy_q <= 1'b1;
      idx    <= '0;
      ver_q  <= version;
      btn_q  <= buttons;
      smp_q  <= samples;
    end else if (done) begin
      busy_q <= 1'b0;
      idx    <= '0;
      fno    <= fno + 8'd1;
    end else if (fire) begin
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      overrun_count <= '0;
    else if (busy_q && start && overrun_count != {OVR_W{1'b1}})
      overrun_count <= overrun_count + 1'b1;
  end

  assign frame_b[0] = SYNC_HI;
  assign frame_b[1] = SYNC_LO;
  assign frame_b[2] = ver_q;
  assign frame_b[3] = fno;
  assign frame_b[NBYTES-1] = {4'b0000, btn_q};

  for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
    assign frame_b[CH_BASE + 2*g]     = smp_q[16*g +: 8];
    assign frame_b[CH_BASE + 2*g + 1] = smp_q[16*g + 8 +: 8];
  end

  assign tx_data = frame_b[idx];

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R7
  AST_START_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> tx_data == SYNC_HI); // R2
  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start |=> busy); // R10
  AST_FNO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> fno == $past(fno) + 8'd1 && !busy); // R3
  AST_OVR_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && start) |=> $stable(overrun_count)); // R9
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> idx <= LAST); // R6

endmodule

// File: tb/tb_sample_framer.sv
module tb_sample_framer;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] version = '0;
  logic [3:0] buttons = '0;
  logic [95:0] samples = '0;
  logic busy, tx_valid, tx_data_unused;
  logic tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic [7:0] overrun_count;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_fno = 8'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_framer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .version(version),
    .buttons(buttons), .samples(samples), .busy(busy), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .overrun_count(overrun_count)
  );

  assign tx_data_unused = 1'b0;

  // {version[7:0], buttons[3:0], samples[95:0]}
  localparam logic [107:0] VEC [4] = '{
    {8'h01, 4'h0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    {8'h02, 4'h5, 16'h03FF, 16'h0201, 16'h0100, 16'h0080, 16'h0012, 16'h0345},
    {8'hC3, 4'hA, 16'hFFFF, 16'h1234, 16'hABCD, 16'h00FF, 16'hFF00, 16'h8001},
    {8'h7E, 4'hF, 16'h5A5A, 16'hA5A5, 16'h0001, 16'h8000, 16'h7FFF, 16'hDEAD}
  };
  localparam logic [7:0] PAT [4] = '{8'hFF, 8'b1010_0110, 8'b0001_0001, 8'b1100_1011};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [107:0] v, input logic [7:0] fn, input int i);
    if (i == 0) return 8'hA5;
    if (i == 1) return 8'h5A;
    if (i == 2) return v[107:100];
    if (i == 3) return fn;
    if (i == 16) return {4'b0000, v[99:96]};
    return v[(i-4)*8 +: 8];
  endfunction

  function automatic string req_of(input int i);
    if (i < 2) return "R2";
    if (i < 4) return "R3";
    if (i < 16) return "R4";
    return "R5";
  endfunction

  task automatic run_frame(input logic [107:0] v, input logic [7:0] pat, input bit full,
                           input int ovr_at, input int ovr_len);
    int got = 0;
    int cyc = 0;
    bit stalled = 1'b0;
    logic [7:0] held = '0;
    @(negedge clk);
    {version, buttons, samples} = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    {version, buttons, samples} = ~v; // R8: scrambled inputs must not reach the frame
    if (full) chk("R10", {31'd0, busy & tx_valid}, 32'd1);
    while (got < NB) begin
      if (full && stalled) chk("R7", {24'd0, tx_data}, {24'd0, held});
      tx_ready = pat[cyc % 8];
      start = (ovr_at >= 0 && cyc >= ovr_at && cyc < ovr_at + ovr_len);
      if (tx_valid && tx_ready) begin
        if (full || got == 3) chk(req_of(got), {24'd0, tx_data}, {24'd0, exp_byte(v, exp_fno, got)});
        got++;
        stalled = 1'b0;
      end else if (tx_valid) begin
        stalled = 1'b1;
        held = tx_data;
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    tx_ready = 1'b0;
    exp_fno = exp_fno + 8'd1;
    if (full) chk("R6", {30'd0, busy, tx_valid}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] ovr0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {30'd0, busy, tx_valid}, 32'd0);
    chk("R1", {24'd0, overrun_count}, 32'd0);
    // R1: first frame carries frame number 0 (checked as byte 4 of VEC[0])
    for (int i = 0; i < 4; i++) run_frame(VEC[i], PAT[i], 1'b1, -1, 0);

    // R9: single strobe while busy
    ovr0 = overrun_count;
    run_frame(VEC[2], 8'b0110_1101, 1'b1, 5, 1);
    chk("R9", {24'd0, overrun_count}, {24'd0, ovr0 + 8'd1});
    // R9: three-cycle strobe while busy
    ovr0 = overrun_count;
    run_frame(VEC[1], 8'hFF, 1'b1, 2, 3);
    chk("R9", {24'd0, overrun_count}, {24'd0, ovr0 + 8'd3});

    // R3: frame number wraps after 255
    for (int f = 0; f < 258; f++) run_frame(VEC[f % 4], 8'hFF, 1'b0, -1, 0);
    run_frame(VEC[3], 8'hFF, 1'b1, -1, 0);

    // R9: saturation with the frame stalled at its first byte
    @(negedge clk);
    tx_ready = 1'b0;
    {version, buttons, samples} = VEC[1];
    start = 1'b1;
    @(negedge clk);
    repeat (300) @(negedge clk);
    chk("R9", {24'd0, overrun_count}, 32'd255);
    chk("R7", {24'd0, tx_data}, 32'hA5);
    start = 1'b0;
    tx_ready = 1'b1;
    for (int i = 0; i < NB; i++) begin
      chk(req_of(i), {24'd0, tx_data}, {24'd0, exp_byte(VEC[1], exp_fno, i)});
      @(negedge clk);
    end
    exp_fno = exp_fno + 8'd1;
    tx_ready = 1'b0;
    chk("R6", {30'd0, busy, tx_valid}, 32'd0);
    chk("R9", {24'd0, overrun_count}, 32'd255);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule